// File: doc/BRIEF.md
# Video-RAM Block Copy Engine

This block moves bytes from a general source memory into video RAM on behalf of the processor. Software loads a 16-bit source pointer and a 16-bit destination pointer as four byte registers, then writes a control byte that chooses the transfer style and its length. In immediate mode the whole length is copied at once. In blanking mode the copy is cut into 16-byte blocks, one block per horizontal blanking interval, so the display is never disturbed mid-line. While a block runs, the processor is held through a stall output. When the stall lifts, a one-cycle done pulse marks the end of the block.

The register port has five byte registers selected by `reg_sel`: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control. Only the control register reads back, on `ctrl_rdata`. Control bit 7 is the mode: 1 for blanking, 0 for immediate. Bits 6:0 hold the block count minus one. The source memory has a read latency of one cycle: data for a read issued in one cycle is on `src_rdata` in the next. The destination accepts a write in any cycle. Neither memory port applies back-pressure, so no ready signal exists and the engine runs at a fixed cadence. The video timing generator outside this block supplies `lcd_on` and `video_mode`, where mode 0 is horizontal blanking.

Top module: `vdma_engine`

## Requirements
- R1: The transfer source is the 16-bit source pointer with its low four bits forced to zero. The transfer destination is the destination pointer ANDed with 0x1FF0 and then ORed with 0x8000.
- R2: A control write whose aligned source lies in 0x8000–0x9FFF is refused. The read-back becomes the written byte with bit 7 set, no memory access occurs and the stall stays low.
- R3: An immediate-mode control write (bit 7 = 0) copies ((value & 0x7F) + 1) × 16 bytes. The read-back is value & 0x7F while the copy runs.
- R4: Each byte takes exactly two cycles: a source read in one cycle, then the destination write of the returned data in the next. Both addresses rise by one per byte, and the stall is high for every cycle of the block.
- R5: When an immediate-mode block ends, the read-back becomes 0xFF and the advanced source and destination are stored back into the pointer registers. A later control write without new pointers therefore continues where the copy stopped.
- R6: A blanking-mode control write made while the display is on and the video mode is 0 copies one 16-byte block at once. The read-back is value & 0x7F and falls by one at the end of each block.
- R7: A pending blanking transfer copies a further 16-byte block on each entry into video mode 0 while the display is on. No block is copied while the mode merely stays at 0, or on an entry while the display is off.
- R8: A blanking transfer ends when the read-back falls from 0x00 to 0xFF. Later mode-0 entries then copy nothing.
- R9: A blanking-mode control write made while the display is off copies nothing at once. The read-back is 0x80 | ((value + 1) & 0x7F).
- R10: An immediate-mode control write made while a blanking transfer is pending, and outside an active mode-0 period with the display on, copies nothing. It cancels the pending transfer, and the read-back is value & 0x7F.
- R11: `blk_done` is high for exactly one cycle, the first cycle in which the stall is low after a block.
- R12: Register writes made while the stall is high have no effect.
- R13: After reset the read-back is 0xFF, the stall is low, and no memory access takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..4) |
| reg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control register read-back |
| lcd_on | input | 1 | Display enabled |
| video_mode | input | 2 | Current video mode, 0 = horizontal blanking |
| src_rd | output | 1 | Source read request |
| src_addr | output | 16 | Source read address |
| src_rdata | input | 8 | Source data, one cycle after the request |
| dst_wr | output | 1 | Video RAM write strobe |
| dst_addr | output | 16 | Video RAM write address |
| dst_wdata | output | 8 | Video RAM write data |
| cpu_stall | output | 1 | Holds the processor while a block runs |
| blk_done | output | 1 | One-cycle end-of-block pulse |

## Verification
A wrong pointer or length count shows up on the very next destination write, as a wrong address or data byte, or as a block that is longer or shorter than 16 × n. Every write is compared against an address and data sequence computed independently of the design. A wrong pending flag or read-back state does not show at once. It appears at the next mode-0 entry as a block that is missing or extra, or on the read-back after the block, so the blanking scenarios walk through several entries, including entries with the display off and entries after the end of the transfer.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_t;

  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;

  localparam logic [15:0] SRC_ALIGN_MASK = 16'hFFF0;
  localparam logic [15:0] DST_OFS_MASK   = 16'h1FF0;
  localparam logic [15:0] DST_BASE       = 16'h8000;
  localparam logic [2:0]  VRAM_WINDOW    = 3'b100;
  localparam logic [7:0]  RB_IDLE        = 8'hFF;
endpackage

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic              go,
  input  logic [CNT_W-1:0]  go_len,
  output logic              busy,
  output logic              src_rd,
  output logic [ADDR_W-1:0] src_addr,
  output logic              dst_wr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              blk_end,
  output logic [ADDR_W-1:0] src_after,
  output logic [ADDR_W-1:0] dst_after,
  output logic              done
);
  mv_state_t         st;
  logic [ADDR_W-1:0] sp, dp;
  logic [CNT_W-1:0]  left;
  logic              done_q;
  logic              last;

  assign last = (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= MV_IDLE;
      sp     <= '0;
      dp     <= '0;
      left   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ld) begin
        sp <= ld_src;
        dp <= ld_dst;
      end
      case (st)
        MV_IDLE: if (go) begin
          left <= go_len;
          st   <= MV_READ;
        end
        MV_READ: st <= MV_WRITE;
        MV_WRITE: begin
          sp   <= sp + ADDR_W'(1);
          dp   <= dp + ADDR_W'(1);
          left <= left - CNT_W'(1);
          if (last) begin
            st     <= MV_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= MV_READ;
          end
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  assign busy      = (st != MV_IDLE);
  assign src_rd    = (st == MV_READ);
  assign dst_wr    = (st == MV_WRITE);
  assign src_addr  = sp;
  assign dst_addr  = dp;
  assign blk_end   = (st == MV_WRITE) && last;
  assign src_after = sp + ADDR_W'(1);
  assign dst_after = dp + ADDR_W'(1);
  assign done      = done_q;
endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int LEN_W     = 7,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic             lcd_on,
  input  logic [1:0]       video_mode,
  input  logic             busy,
  input  logic             blk_end,
  input  logic [15:0]      src_after,
  input  logic [15:0]      dst_after,
  output logic [7:0]       ctrl_rdata,
  output logic             ld,
  output logic [15:0]      ld_src,
  output logic [15:0]      ld_dst,
  output logic             go,
  output logic [CNT_W-1:0] go_len
);
  localparam int BLK_SHIFT = $clog2(BLK_BYTES);

  logic [7:0] src_hi, src_lo, dst_hi, dst_lo, rb;
  logic       pending;
  logic [1:0] prev_mode;

  logic ctl_wr, bad_src, hb_now, hb_entry, start_ok, accept, go_write, go_hb, v_blank;
  logic [7:0] rb_dec;

  assign v_blank  = reg_wdata[7];
  assign ctl_wr   = reg_wr && !busy && (reg_sel == SEL_CTRL);
  assign ld_src   = {src_hi, src_lo} & SRC_ALIGN_MASK;
  assign ld_dst   = ({dst_hi, dst_lo} & DST_OFS_MASK) | DST_BASE;
  assign bad_src  = (ld_src[15:13] == VRAM_WINDOW);
  assign hb_now   = lcd_on && (video_mode == 2'd0);
  assign hb_entry = hb_now && (prev_mode != 2'd0);
  assign start_ok = (!pending && !v_blank) || hb_now;
  assign accept   = ctl_wr && !bad_src;
  assign go_write = accept && start_ok;
  assign go_hb    = pending && hb_entry && !busy && !ctl_wr;
  assign ld       = accept;
  assign go       = go_write || go_hb;
  assign go_len   = (go_write && !v_blank)
                    ? ((CNT_W'(reg_wdata[LEN_W-1:0]) + CNT_W'(1)) << BLK_SHIFT)
                    : CNT_W'(BLK_BYTES);
  assign rb_dec   = rb - 8'd1;
  assign ctrl_rdata = rb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi    <= '0;
      src_lo    <= '0;
      dst_hi    <= '0;
      dst_lo    <= '0;
      rb        <= RB_IDLE;
      pending   <= 1'b0;
      prev_mode <= 2'd0;
    end else begin
      prev_mode <= video_mode;
      if (blk_end) begin
        {src_hi, src_lo} <= src_after;
        {dst_hi, dst_lo} <= dst_after;
        if (pending) begin
          rb <= rb_dec;
          if (rb_dec == RB_IDLE) pending <= 1'b0;
        end else begin
          rb <= RB_IDLE;
        end
      end
      if (reg_wr && !busy) begin
        case (reg_sel)
          SEL_SRC_HI: src_hi <= reg_wdata;
          SEL_SRC_LO: src_lo <= reg_wdata;
          SEL_DST_HI: dst_hi <= reg_wdata;
          SEL_DST_LO: dst_lo <= reg_wdata;
          SEL_CTRL: begin
            if (bad_src) begin
              rb <= reg_wdata | 8'h80;
            end else begin
              pending <= v_blank;
              if (!start_ok && v_blank && !lcd_on)
                rb <= 8'h80 | ((reg_wdata + 8'd1) & 8'h7F);
              else
                rb <= reg_wdata & 8'h7F;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int LEN_W     = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  ctrl_rdata,
  input  logic        lcd_on,
  input  logic [1:0]  video_mode,
  output logic        src_rd,
  output logic [15:0] src_addr,
  input  logic [7:0]  src_rdata,
  output logic        dst_wr,
  output logic [15:0] dst_addr,
  output logic [7:0]  dst_wdata,
  output logic        cpu_stall,
  output logic        blk_done
);
  localparam int CNT_W = LEN_W + $clog2(BLK_BYTES) + 1;

  logic             ld, go, busy, blk_end;
  logic [15:0]      ld_src, ld_dst, src_after, dst_after;
  logic [CNT_W-1:0] go_len;

  vdma_regs #(.BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .lcd_on(lcd_on), .video_mode(video_mode),
    .busy(busy), .blk_end(blk_end), .src_after(src_after), .dst_after(dst_after),
    .ctrl_rdata(ctrl_rdata), .ld(ld), .ld_src(ld_src), .ld_dst(ld_dst),
    .go(go), .go_len(go_len)
  );

  vdma_mover #(.ADDR_W(16), .CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_src(ld_src), .ld_dst(ld_dst),
    .go(go), .go_len(go_len), .busy(busy), .src_rd(src_rd), .src_addr(src_addr),
    .dst_wr(dst_wr), .dst_addr(dst_addr), .blk_end(blk_end),
    .src_after(src_after), .dst_after(dst_after), .done(blk_done)
  );

  assign dst_wdata = src_rdata;
  assign cpu_stall = busy;
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_rd,
  input logic        dst_wr,
  input logic [15:0] dst_addr,
  input logic        cpu_stall,
  input logic        blk_done
);
  // R4: a read is always followed by its write
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> dst_wr);
  // R4: a write always follows a read
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr |-> $past(src_rd));
  // R4: consecutive writes step the destination by one
  a_r4_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr && $past(dst_wr, 2) && $past(rst_n, 2)) |-> (dst_addr == $past(dst_addr, 2) + 16'd1));
  // R4: memory traffic only under stall
  a_r4_stall_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd || dst_wr) |-> cpu_stall);
  // R11: done only as the stall drops
  a_r11_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (!cpu_stall && $past(cpu_stall)));
  // R11: every release raises done
  a_r11_release_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> blk_done);
  // R11: one-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);
endmodule

bind vdma_engine vdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_rd(src_rd), .dst_wr(dst_wr),
  .dst_addr(dst_addr), .cpu_stall(cpu_stall), .blk_done(blk_done)
);

// File: tb/vdma_engine_bench.sv
module vdma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  ctrl_rdata;
  logic        lcd_on = 1'b0;
  logic [1:0]  video_mode = 2'd2;
  logic        src_rd;
  logic [15:0] src_addr;
  logic [7:0]  src_rdata = 8'd0;
  logic        dst_wr;
  logic [15:0] dst_addr;
  logic [7:0]  dst_wdata;
  logic        cpu_stall;
  logic        blk_done;

  int checks = 0, errors = 0;
  int nbytes = 0, nstall = 0, ndone = 0;
  logic [15:0] exp_src = 16'd0, exp_dst = 16'd0;
  logic prev_stall = 1'b0;

  always #10 clk = ~clk;

  vdma_engine u_vdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .lcd_on(lcd_on),
    .video_mode(video_mode), .src_rd(src_rd), .src_addr(src_addr),
    .src_rdata(src_rdata), .dst_wr(dst_wr), .dst_addr(dst_addr),
    .dst_wdata(dst_wdata), .cpu_stall(cpu_stall), .blk_done(blk_done)
  );

  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (src_rd) src_rdata <= pattern(src_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (dst_wr) begin
        chk(dst_addr == exp_dst, "R4 dst address", dst_addr, exp_dst);
        chk(dst_wdata == pattern(exp_src), "R4 data", dst_wdata, pattern(exp_src));
        nbytes++;
        exp_src++;
        exp_dst++;
      end
      if (cpu_stall) nstall++;
      if (blk_done) begin
        ndone++;
        chk(!cpu_stall && prev_stall, "R11 done timing", cpu_stall, 0);
      end
      prev_stall = cpu_stall;
    end
  end

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
    wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!cpu_stall) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_counts();
    nbytes = 0; nstall = 0; ndone = 0;
  endtask

  task automatic set_vid(input logic on, input logic [1:0] m);
    @(negedge clk);
    lcd_on = on; video_mode = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ctrl_rdata == 8'hFF, "R13 readback", ctrl_rdata, 8'hFF);
    chk(!cpu_stall && !src_rd && !dst_wr, "R13 idle", {cpu_stall, src_rd, dst_wr}, 0);
  endtask

  task automatic t_general();
    set_vid(1'b1, 2'd2);
    set_ptrs(16'h1234, 16'hC345);
    exp_src = 16'h1230; exp_dst = 16'h8340;   // R1 alignment and remap
    clear_counts();
    wr_reg(3'd4, 8'h02);
    chk(cpu_stall, "R4 stall at start", cpu_stall, 1);
    chk(ctrl_rdata == 8'h02, "R3 readback running", ctrl_rdata, 8'h02);
    wait_idle();
    chk(nbytes == 48, "R3 length", nbytes, 48);
    chk(nstall == 96, "R4 two cycles per byte", nstall, 96);
    chk(ndone == 1, "R11 one done", ndone, 1);
    chk(ctrl_rdata == 8'hFF, "R5 readback after", ctrl_rdata, 8'hFF);
    chk(exp_dst == 16'h8370, "R1 destination end", exp_dst, 16'h8370);
  endtask

  task automatic t_continue();
    clear_counts();
    wr_reg(3'd4, 8'h00);   // R5: pointers written back, copy resumes
    wait_idle();
    chk(nbytes == 16, "R5 resumed length", nbytes, 16);
    chk(exp_src == 16'h1270, "R5 resumed source", exp_src, 16'h1270);
  endtask

  task automatic t_ignore();
    set_ptrs(16'h2000, 16'h0000);
    exp_src = 16'h2000; exp_dst = 16'h8000;
    clear_counts();
    wr_reg(3'd4, 8'h00);
    wr_reg(3'd4, 8'h7F);   // R12: during stall
    wr_reg(3'd1, 8'h80);
    wait_idle();
    chk(nbytes == 16, "R12 length unchanged", nbytes, 16);
    chk(ctrl_rdata == 8'hFF, "R12 readback", ctrl_rdata, 8'hFF);
    clear_counts();
    wr_reg(3'd4, 8'h00);   // continues from write-back, not from 0x2080
    wait_idle();
    chk(exp_src == 16'h2020 && nbytes == 16, "R12 pointer untouched", exp_src, 16'h2020);
  endtask

  task automatic t_reject();
    set_ptrs(16'h8800, 16'h0100);
    clear_counts();
    wr_reg(3'd4, 8'h05);
    chk(!cpu_stall, "R2 no stall", cpu_stall, 0);
    repeat (20) @(negedge clk);
    chk(ctrl_rdata == 8'h85, "R2 readback", ctrl_rdata, 8'h85);
    chk(nbytes == 0, "R2 no copy", nbytes, 0);
  endtask

  task automatic t_blank_on();
    set_vid(1'b1, 2'd0);
    set_ptrs(16'h4000, 16'h1000);
    exp_src = 16'h4000; exp_dst = 16'h9000;
    clear_counts();
    wr_reg(3'd4, 8'h82);
    chk(ctrl_rdata == 8'h02, "R6 readback", ctrl_rdata, 8'h02);
    wait_idle();
    chk(nbytes == 16, "R6 first block", nbytes, 16);
    chk(ctrl_rdata == 8'h01, "R6 decrement", ctrl_rdata, 8'h01);
    repeat (10) @(negedge clk);
    chk(nbytes == 16, "R7 no block while mode stays 0", nbytes, 16);
    set_vid(1'b1, 2'd2);
    set_vid(1'b1, 2'd0);
    wait_idle();
    chk(nbytes == 32 && ctrl_rdata == 8'h00, "R7 second block", nbytes, 32);
    set_vid(1'b0, 2'd1);
    set_vid(1'b0, 2'd0);
    chk(nbytes == 32, "R7 no block with display off", nbytes, 32);
    set_vid(1'b1, 2'd3);
    set_vid(1'b1, 2'd0);
    wait_idle();
    chk(nbytes == 48, "R8 last block", nbytes, 48);
    chk(ctrl_rdata == 8'hFF, "R8 wrap ends", ctrl_rdata, 8'hFF);
    set_vid(1'b1, 2'd2);
    set_vid(1'b1, 2'd0);
    wait_idle();
    chk(nbytes == 48, "R8 no block after end", nbytes, 48);
  endtask

  task automatic t_blank_off();
    set_vid(1'b0, 2'd2);
    set_ptrs(16'h5000, 16'h0200);
    clear_counts();
    wr_reg(3'd4, 8'h83);
    repeat (4) @(negedge clk);
    chk(ctrl_rdata == 8'h84, "R9 readback", ctrl_rdata, 8'h84);
    chk(nbytes == 0, "R9 no copy", nbytes, 0);
    wr_reg(3'd4, 8'h01);
    repeat (4) @(negedge clk);
    chk(nbytes == 0, "R10 no copy", nbytes, 0);
    chk(ctrl_rdata == 8'h01, "R10 readback", ctrl_rdata, 8'h01);
    set_vid(1'b1, 2'd0);
    repeat (6) @(negedge clk);
    chk(nbytes == 0, "R10 cancelled", nbytes, 0);
    set_vid(1'b0, 2'd2);
    wr_reg(3'd4, 8'hFF);
    repeat (4) @(negedge clk);
    chk(ctrl_rdata == 8'h80, "R9 wrap readback", ctrl_rdata, 8'h80);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_general();
    t_continue();
    t_ignore();
    t_reject();
    t_blank_on();
    t_blank_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule